// File: doc/BRIEF.md
# DSP Status Register with Result Saturation

This block is the status and control word of a 16-bit signal processor. The upper six bits belong to hardware. Four of them are arithmetic flags (negative, overflow, zero, carry), which an ALU operation loads. The other two follow a pair of external user input pins through a two-stage synchronizer. Software can read these six bits but cannot write them. The lower ten bits are written by software. They hold the controls for result scaling, overflow clamping, interrupt enable, two user outputs, two short-form addressing bits and a 3-bit circular-pointer loop size code.

Ahead of the register sits a combinational post-processing stage that takes a wide signed multiplier/ALU value. When the scale bit is set and the current operation uses the multiplier, the stage shifts the value arithmetically right by three. It then narrows the value to a 32-bit result. An out-of-range value either wraps, keeping its low bits, or is clamped to the most positive or most negative 32-bit value, as the clamp bit selects. The flags loaded on an update describe this final result. The loop size code is decoded into a modulo mask for the pointer logic.

Top module: `dsp_stat_reg`

## Requirements
- R1: While reset is asserted, the read value is 0x0000, both user output pins are high, the interrupt enable output is low and the loop mask is 0xFF.
- R2: A software write loads the 10-bit write data into read bits 9..0 on the next clock edge. Bits 15..10 are not changed by a write, and bits 9..0 hold their value in any cycle without a write.
- R3: On a flag update, the next edge loads bit 15 with bit 31 of the result, bit 14 with overflow, bit 13 with (result == 0) and bit 12 with the carry input. Without an update, bits 15..12 hold their value.
- R4: User input pin k reaches read bit 10+k on the third clock edge after it changes, and not earlier.
- R5: User output pin 0 is the inverse of bit 5, and user output pin 1 is the inverse of bit 6.
- R6: The interrupt enable output equals bit 7.
- R7: When bit 8 is 1, a value outside the signed 32-bit range gives 0x7FFFFFFF if it is positive and 0x80000000 if it is negative, and the overflow flag is set.
- R8: When bit 8 is 0, a value outside the signed 32-bit range gives its low 32 bits, and the overflow flag is set. An in-range value passes through unchanged with overflow clear.
- R9: When bit 9 is 1 and the multiplier select input is high, the input value is arithmetically shifted right by three before the range check. With either condition false, no shift is applied.
- R10: Loop size code bits 2..0 set the loop mask. A code k from 1 to 7 gives a mask of 2^k-1, and code 0 gives 0xFF.
- R11: A write and a flag update in the same cycle both take effect on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe for bits 9..0 |
| sw_wdata_i | input | 10 | Software write data for bits 9..0 |
| alu_upd_i | input | 1 | Load the flags from the current result |
| alu_c_i | input | 1 | Carry from the ALU |
| mpy_sel_i | input | 1 | Current operation uses the multiplier path |
| acc_i | input | RES_W | Wide signed ALU/multiplier value |
| usr_in_i | input | 2 | Asynchronous user input pins |
| res_o | output | OUT_W | Scaled and saturated or wrapped result |
| rd_data_o | output | 16 | Full status word |
| usr_out_o | output | 2 | User output pins, inverted from bits 6..5 |
| irq_en_o | output | 1 | Interrupt enable |
| loop_mask_o | output | 8 | Modulo mask for the circular pointer |

## Verification
The hardest case to reach is a wide value that goes out of the 32-bit range only after the shift. It must be checked both clamped and wrapped, with the flags captured from the narrowed result, not from the raw input. The vector table first writes the scale and clamp bits through the normal write port and waits one edge. It then applies values chosen at 2^31 and at -(2^31+1), at 2^34 with the shift, and at the largest value that still fits after the shift. The single cycle that combines a write with a flag update is driven directly, and the full 16-bit word is compared afterwards.

// File: rtl/dsp_stat_pkg.sv
package dsp_stat_pkg;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned CTL_W  = 10;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned UI_W   = 2;
  localparam int unsigned RPL_W  = 3;
  localparam int unsigned MASK_W = 1 << RPL_W;

  // control bit positions inside the software-owned field
  localparam int unsigned B_SCALE = 9;
  localparam int unsigned B_CLAMP = 8;
  localparam int unsigned B_IE    = 7;
  localparam int unsigned B_UO1   = 6;
  localparam int unsigned B_UO0   = 5;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/dsp_stat_sync.sv
module dsp_stat_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stg_q[s] <= stg_q[s-1];
      stg_q[0] <= d_i;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dsp_stat_post.sv
module dsp_stat_post #(
  parameter int unsigned IN_W  = 36,
  parameter int unsigned OUT_W = 32,
  parameter int unsigned SHIFT = 3
) (
  input  logic [IN_W-1:0]  acc_i,
  input  logic             scale_i,
  input  logic             clamp_i,
  output logic [OUT_W-1:0] res_o,
  output logic             ovf_o
);
  localparam int unsigned HI_W = IN_W - OUT_W + 1;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] acc_s, scaled;
  logic [HI_W-1:0] hi;

  always_comb begin
    acc_s  = signed'(acc_i);
    scaled = scale_i ? (acc_s >>> SHIFT) : acc_s;
    // value fits when the bits above the result sign all equal it
    hi     = scaled[IN_W-1:OUT_W-1];
    ovf_o  = !((&hi) || !(|hi));
    if (ovf_o && clamp_i) res_o = scaled[IN_W-1] ? NEG_MIN : POS_MAX;
    else                  res_o = scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/dsp_stat_loop_dec.sv
module dsp_stat_loop_dec #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned MASK_W = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [MASK_W-1:0] mask_o
);
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    // code 0 selects the largest loop
    assign mask_o[i] = (code_i == '0) || (code_i > CODE_W'(i));
  end
endmodule

// File: rtl/dsp_stat_reg.sv
module dsp_stat_reg
  import dsp_stat_pkg::*;
#(
  parameter int unsigned RES_W       = 36,
  parameter int unsigned OUT_W       = 32,
  parameter int unsigned SHIFT       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTL_W-1:0]  sw_wdata_i,
  input  logic              alu_upd_i,
  input  logic              alu_c_i,
  input  logic              mpy_sel_i,
  input  logic [RES_W-1:0]  acc_i,
  input  logic [UI_W-1:0]   usr_in_i,
  output logic [OUT_W-1:0]  res_o,
  output logic [STAT_W-1:0] rd_data_o,
  output logic [1:0]        usr_out_o,
  output logic              irq_en_o,
  output logic [MASK_W-1:0] loop_mask_o
);
  flags_t           flag_q, flag_d;
  logic [UI_W-1:0]  ui_q, ui_sync;
  logic [CTL_W-1:0] ctl_q;
  logic             ovf;

  dsp_stat_sync #(.W(UI_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (usr_in_i),
    .q_o    (ui_sync)
  );

  dsp_stat_post #(.IN_W(RES_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_post (
    .acc_i   (acc_i),
    .scale_i (ctl_q[B_SCALE] & mpy_sel_i),
    .clamp_i (ctl_q[B_CLAMP]),
    .res_o   (res_o),
    .ovf_o   (ovf)
  );

  dsp_stat_loop_dec #(.CODE_W(RPL_W)) u_loop (
    .code_i (ctl_q[RPL_W-1:0]),
    .mask_o (loop_mask_o)
  );

  always_comb begin
    flag_d.n = res_o[OUT_W-1];
    flag_d.v = ovf;
    flag_d.z = (res_o == '0);
    flag_d.c = alu_c_i;
  end

  // hardware and software fields are disjoint, so both may load in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      ui_q   <= '0;
      ctl_q  <= '0;
    end else begin
      ui_q <= ui_sync;
      if (alu_upd_i) flag_q <= flag_d;
      if (wr_en_i)   ctl_q  <= sw_wdata_i;
    end
  end

  assign rd_data_o = {flag_q, ui_q, ctl_q};
  assign usr_out_o = ~{ctl_q[B_UO1], ctl_q[B_UO0]};
  assign irq_en_o  = ctl_q[B_IE];
endmodule

// File: rtl/dsp_stat_reg_chk.sv
module dsp_stat_reg_chk
  import dsp_stat_pkg::*;
#(
  parameter int unsigned OUT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [CTL_W-1:0]  sw_wdata_i,
  input logic              alu_upd_i,
  input logic [UI_W-1:0]   usr_in_i,
  input logic [OUT_W-1:0]  res_o,
  input logic              ovf,
  input logic [STAT_W-1:0] rd_data_o,
  input logic [1:0]        usr_out_o,
  input logic              irq_en_o,
  input logic [MASK_W-1:0] loop_mask_o
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end

  AST_WR_CTL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[CTL_W-1:0] == $past(sw_wdata_i)); // R2
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o[CTL_W-1:0])); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_upd_i |=> $stable(rd_data_o[15:12])); // R3
  AST_FLAG_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_upd_i |=> rd_data_o[13] == ($past(res_o) == '0)); // R3
  AST_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> rd_data_o[11:10] == $past(usr_in_i, 3)); // R4
  AST_UOUT_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usr_out_o == ~rd_data_o[6:5]); // R5
  AST_IRQ_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_o == rd_data_o[7]); // R6
  AST_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[8] && ovf) |-> (res_o == POS_MAX || res_o == NEG_MIN)); // R7
  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_upd_i |=> rd_data_o[14] == $past(ovf)); // R8
  AST_MASK_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_mask_o[0] && ((MASK_W'(loop_mask_o + 1'b1) & loop_mask_o) == '0)); // R10
  AST_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && alu_upd_i) |=> (rd_data_o[CTL_W-1:0] == $past(sw_wdata_i)
                                && rd_data_o[14] == $past(ovf))); // R11
endmodule

bind dsp_stat_reg dsp_stat_reg_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/dsp_stat_reg_test.sv
`timescale 1ns/1ps
module dsp_stat_reg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [9:0]  sw_wdata_i = '0;
  logic        alu_upd_i = 1'b0;
  logic        alu_c_i = 1'b0;
  logic        mpy_sel_i = 1'b0;
  logic [35:0] acc_i = '0;
  logic [1:0]  usr_in_i = '0;
  logic [31:0] res_o;
  logic [15:0] rd_data_o;
  logic [1:0]  usr_out_o;
  logic        irq_en_o;
  logic [7:0]  loop_mask_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dsp_stat_reg uut (.*);

  typedef struct packed {
    logic [1:0]  ctl;   // {scale bit 9, clamp bit 8}
    logic        mpy;
    logic [35:0] acc;
    logic [31:0] res;
    logic        v;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 36'h000001234, 32'h00001234, 1'b0},
    '{2'b00, 1'b0, 36'h000000000, 32'h00000000, 1'b0},
    '{2'b00, 1'b0, 36'h080000000, 32'h80000000, 1'b1},
    '{2'b01, 1'b0, 36'h080000000, 32'h7FFFFFFF, 1'b1},
    '{2'b01, 1'b0, 36'hF7FFFFFFF, 32'h80000000, 1'b1},
    '{2'b00, 1'b0, 36'hF7FFFFFFF, 32'h7FFFFFFF, 1'b1},
    '{2'b10, 1'b1, 36'h000000040, 32'h00000008, 1'b0},
    '{2'b10, 1'b0, 36'h000000040, 32'h00000040, 1'b0},
    '{2'b10, 1'b1, 36'hFFFFFFFF8, 32'hFFFFFFFF, 1'b0},
    '{2'b10, 1'b1, 36'hFFFFFFFF9, 32'hFFFFFFFF, 1'b0},
    '{2'b10, 1'b1, 36'h400000000, 32'h80000000, 1'b1},
    '{2'b11, 1'b1, 36'h400000000, 32'h7FFFFFFF, 1'b1},
    '{2'b11, 1'b1, 36'h3FFFFFFF8, 32'h7FFFFFFF, 1'b0},
    '{2'b01, 1'b0, 36'h07FFFFFFF, 32'h7FFFFFFF, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic sw_write(input logic [9:0] d);
    wr_en_i = 1'b1;
    sw_wdata_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] fl_prev;
    string tag;
    repeat (3) @(negedge clk_i);
    check("R1", "reset rd", 40'(rd_data_o), 40'h0);
    check("R1", "reset usr_out", 40'(usr_out_o), 40'h3);
    check("R1", "reset irq_en", 40'(irq_en_o), 40'h0);
    check("R1", "reset loop mask", 40'(loop_mask_o), 40'hFF);
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      sw_write({VECS[i].ctl, 8'h00});
      acc_i = VECS[i].acc;
      mpy_sel_i = VECS[i].mpy;
      alu_c_i = VECS[i].acc[0];
      alu_upd_i = 1'b1;
      #1;
      tag = (VECS[i].ctl[1] && VECS[i].mpy) ? "R9" : (VECS[i].ctl[0] ? "R7" : "R8");
      check(tag, $sformatf("vec %0d result", i), 40'(res_o), 40'(VECS[i].res));
      tick();
      alu_upd_i = 1'b0;
      check("R3", $sformatf("vec %0d flags", i), 40'(rd_data_o[15:12]),
            40'({VECS[i].res[31], VECS[i].v, VECS[i].res == 32'h0, VECS[i].acc[0]}));
    end

    // write leaves hardware field untouched
    fl_prev = rd_data_o[15:12];
    sw_write(10'h3FF);
    check("R2", "ctl after write", 40'(rd_data_o[9:0]), 40'h3FF);
    check("R2", "flags after write", 40'(rd_data_o[15:12]), 40'(fl_prev));
    check("R5", "usr_out both set", 40'(usr_out_o), 40'h0);
    check("R6", "irq_en set", 40'(irq_en_o), 40'h1);

    // no update: flags hold while result changes
    acc_i = '0;
    mpy_sel_i = 1'b0;
    tick();
    tick();
    check("R3", "flags hold", 40'(rd_data_o[15:12]), 40'(fl_prev));
    check("R2", "ctl hold", 40'(rd_data_o[9:0]), 40'h3FF);

    sw_write(10'h020);
    check("R5", "usr_out bit5 only", 40'(usr_out_o), 40'h2);
    check("R6", "irq_en clear", 40'(irq_en_o), 40'h0);
    sw_write(10'h040);
    check("R5", "usr_out bit6 only", 40'(usr_out_o), 40'h1);

    for (int k = 0; k < 8; k++) begin
      sw_write(10'(k));
      check("R10", $sformatf("loop code %0d", k), 40'(loop_mask_o),
            (k == 0) ? 40'hFF : 40'((1 << k) - 1));
    end

    // user input latency
    usr_in_i = 2'b10;
    tick();
    check("R4", "ui after 1 edge", 40'(rd_data_o[11:10]), 40'h0);
    tick();
    check("R4", "ui after 2 edges", 40'(rd_data_o[11:10]), 40'h0);
    tick();
    check("R4", "ui after 3 edges", 40'(rd_data_o[11:10]), 40'h2);
    usr_in_i = 2'b01;
    tick();
    tick();
    check("R4", "ui change after 2 edges", 40'(rd_data_o[11:10]), 40'h2);
    tick();
    check("R4", "ui change after 3 edges", 40'(rd_data_o[11:10]), 40'h1);

    // simultaneous write and flag update
    wr_en_i = 1'b1;
    sw_wdata_i = 10'h155;
    alu_upd_i = 1'b1;
    alu_c_i = 1'b0;
    acc_i = '0;
    tick();
    wr_en_i = 1'b0;
    alu_upd_i = 1'b0;
    check("R11", "write plus update", 40'(rd_data_o), 40'({4'b0010, 2'b01, 10'h155}));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule